// File: doc/BRIEF.md
# Branch Table Aliasing Monitor

This block watches the stream of resolved conditional branches and shows when two different (branch address, global history) pairs compete for the same slot of a direct-mapped, tag-less prediction table. It keeps a shadow table with one slot per prediction-table index. Each slot holds the full identity of the last pair that used that index, not a counter. Each incoming branch is mapped to an index in one of two styles, chosen per branch. In XOR mode the low address bits are hashed with the history. In concatenate mode the history fills the low index bits and the remaining upper index bits come from the address.

Each lookup yields a registered result one cycle after the strobe. The result says whether the slot was cold (never used since reset), aliased (in use by a different pair), or clean (same pair as last time). The slot is then rewritten with the current pair. Three running counts are kept: total lookups, aliasing events and cold events. Software divides the aliasing count by the lookup count to obtain the aliasing ratio.

Top module: `alias_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all three counts read zero and `res_valid`, `alias_o` and `cold_o` are low. Every table slot is marked unused.
- R2: `res_valid` is high in the cycle after a clock edge that sampled `br_valid` high, and low in the cycle after an edge that sampled it low. The flags of that lookup appear in the same cycle as `res_valid`.
- R3: A lookup of a slot that has not been written since reset gives `cold_o`=1 and `alias_o`=0.
- R4: A lookup of a written slot whose stored (address, history) pair differs in any bit from the incoming pair gives `alias_o`=1 and `cold_o`=0.
- R5: A lookup of a written slot that holds exactly the incoming pair gives `alias_o`=0 and `cold_o`=0.
- R6: Every lookup overwrites its slot with the incoming pair, whatever the outcome, so the next comparison at that slot is against the most recent user.
- R7: With `mode_sel`=0 (XOR mode), the index is `br_addr[IDX_W-1:0]` XOR (`br_hist` shifted left by IDX_W-HIST_W). The history therefore lands on the upper end of the low address field.
- R8: With `mode_sel`=1 (concatenate mode), the index is {`br_addr[IDX_W-HIST_W-1:0]`, `br_hist`}, with the history in the low bits.
- R9: Each lookup adds one to `branch_count`. Each aliasing result adds one to `alias_count`, and each cold result adds one to `cold_count`. A count changes in the cycle after its lookup's result is shown.
- R10: `alias_o` and `cold_o` are never high together, and both are low whenever `res_valid` is low.
- R11: Cycles with `br_valid` low change neither the counts nor any table slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A resolved conditional branch is presented this cycle |
| br_addr | input | ADDR_W | Branch address |
| br_hist | input | HIST_W | Global history at the branch |
| mode_sel | input | 1 | Index style: 0 XOR, 1 concatenate |
| res_valid | output | 1 | Lookup result present this cycle |
| alias_o | output | 1 | Slot held a different pair |
| cold_o | output | 1 | Slot unused since reset |
| branch_count | output | CNT_W | Lookups since reset |
| alias_count | output | CNT_W | Aliasing events since reset |
| cold_count | output | CNT_W | Cold events since reset |

## Verification
The properties assume that `br_addr`, `br_hist` and `mode_sel` are meaningful only while `br_valid` is high. They also assume that the history is narrower than the index (HIST_W < IDX_W), so both mapping styles have at least one address bit to draw on. The counts are assumed not to wrap within a run. The stimulus drives every input one half cycle away from the capturing edge. It draws addresses from a small pool so that slots collide often, and uses fewer than a few thousand lookups, far below the count range.

// File: rtl/alias_mon_pkg.sv
package alias_mon_pkg;

    typedef enum logic {
        MAP_XOR = 1'b0,
        MAP_CAT = 1'b1
    } map_mode_e;

    typedef struct packed {
        logic aliased;
        logic cold;
    } lookup_ev_t;

    localparam int NUM_CNT = 3;
    localparam int CNT_BRANCH = 0;
    localparam int CNT_ALIAS  = 1;
    localparam int CNT_COLD   = 2;

endpackage

// File: rtl/alias_index.sv
module alias_index #(
    parameter int ADDR_W = 16,
    parameter int HIST_W = 4,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [HIST_W-1:0]         hist,
    input  alias_mon_pkg::map_mode_e  mode,
    output logic [IDX_W-1:0]          idx
);
    localparam int GAP = IDX_W - HIST_W;

    logic [IDX_W-1:0] xor_idx;
    logic [IDX_W-1:0] cat_idx;

    always_comb begin
        xor_idx = addr[IDX_W-1:0] ^ {hist, {GAP{1'b0}}};
        cat_idx = {addr[GAP-1:0], hist};
        idx     = (mode == alias_mon_pkg::MAP_CAT) ? cat_idx : xor_idx;
    end
endmodule

// File: rtl/alias_table.sv
module alias_table #(
    parameter int ID_W  = 20,
    parameter int IDX_W = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       lk_valid,
    input  logic [IDX_W-1:0]           lk_idx,
    input  logic [ID_W-1:0]            lk_id,
    output logic                       res_valid,
    output alias_mon_pkg::lookup_ev_t  res_ev
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ID_W-1:0]  id_mem [DEPTH];
    logic [DEPTH-1:0] used;
    alias_mon_pkg::lookup_ev_t ev_now;

    always_comb begin
        ev_now.cold    = !used[lk_idx];
        ev_now.aliased = used[lk_idx] && (id_mem[lk_idx] != lk_id);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used      <= '0;
            res_valid <= 1'b0;
            res_ev    <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_ev         <= ev_now;
                used[lk_idx]   <= 1'b1;
            end else begin
                res_ev <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (lk_valid && !rst) begin
            id_mem[lk_idx] <= lk_id;
        end
    end
endmodule

// File: rtl/alias_counters.sv
module alias_counters #(
    parameter int CNT_W = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [alias_mon_pkg::NUM_CNT-1:0] bump,
    output logic [CNT_W-1:0]                  cnt [alias_mon_pkg::NUM_CNT]
);
    for (genvar g = 0; g < alias_mon_pkg::NUM_CNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (bump[g]) begin
                cnt[g] <= cnt[g] + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/alias_monitor.sv
module alias_monitor #(
    parameter int ADDR_W = 16,
    parameter int HIST_W = 4,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [HIST_W-1:0] br_hist,
    input  logic              mode_sel,
    output logic              res_valid,
    output logic              alias_o,
    output logic              cold_o,
    output logic [CNT_W-1:0]  branch_count,
    output logic [CNT_W-1:0]  alias_count,
    output logic [CNT_W-1:0]  cold_count
);
    import alias_mon_pkg::*;

    localparam int ID_W = ADDR_W + HIST_W;

    logic [IDX_W-1:0]   idx;
    lookup_ev_t         ev;
    logic [NUM_CNT-1:0] bump;
    logic [CNT_W-1:0]   cnt [NUM_CNT];
    map_mode_e          mode;

    assign mode = map_mode_e'(mode_sel);

    alias_index #(
        .ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(IDX_W)
    ) u_index (
        .addr(br_addr), .hist(br_hist), .mode(mode), .idx(idx)
    );

    alias_table #(
        .ID_W(ID_W), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst(rst), .lk_valid(br_valid), .lk_idx(idx),
        .lk_id({br_addr, br_hist}), .res_valid(res_valid), .res_ev(ev)
    );

    always_comb begin
        bump             = '0;
        bump[CNT_BRANCH] = res_valid;
        bump[CNT_ALIAS]  = res_valid && ev.aliased;
        bump[CNT_COLD]   = res_valid && ev.cold;
    end

    alias_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .bump(bump), .cnt(cnt)
    );

    assign alias_o      = ev.aliased;
    assign cold_o       = ev.cold;
    assign branch_count = cnt[CNT_BRANCH];
    assign alias_count  = cnt[CNT_ALIAS];
    assign cold_count   = cnt[CNT_COLD];
endmodule

// File: rtl/alias_mon_chk.sv
module alias_mon_chk #(
    parameter int ADDR_W = 16,
    parameter int HIST_W = 4,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              br_valid,
    input logic [ADDR_W-1:0] br_addr,
    input logic [HIST_W-1:0] br_hist,
    input logic              mode_sel,
    input logic              res_valid,
    input logic              alias_o,
    input logic              cold_o,
    input logic [CNT_W-1:0]  branch_count,
    input logic [CNT_W-1:0]  alias_count,
    input logic [CNT_W-1:0]  cold_count
);
    assert_result_follows_R2: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> res_valid);
    assert_result_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !br_valid |=> !res_valid);
    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(alias_o && cold_o));
    assert_flags_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!alias_o && !cold_o));
    assert_repeat_clean_R5: assert property (@(posedge clk) disable iff (rst)
        (br_valid && $past(br_valid) && $stable(br_addr) && $stable(br_hist)
         && $stable(mode_sel)) |=> (!alias_o && !cold_o));
    assert_branch_bump_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> branch_count == $past(branch_count) + CNT_W'(1));
    assert_branch_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> $stable(branch_count));
    assert_alias_bump_R9: assert property (@(posedge clk) disable iff (rst)
        alias_o |=> alias_count == $past(alias_count) + CNT_W'(1));
    assert_alias_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !alias_o |=> $stable(alias_count));
    assert_cold_bump_R3: assert property (@(posedge clk) disable iff (rst)
        cold_o |=> cold_count == $past(cold_count) + CNT_W'(1));
endmodule

bind alias_monitor alias_mon_chk #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_addr(br_addr),
    .br_hist(br_hist), .mode_sel(mode_sel), .res_valid(res_valid),
    .alias_o(alias_o), .cold_o(cold_o), .branch_count(branch_count),
    .alias_count(alias_count), .cold_count(cold_count)
);

// File: tb/alias_monitor_tb.sv
`timescale 1ns/1ps
module alias_monitor_tb;
    localparam int ADDR_W = 16;
    localparam int HIST_W = 4;
    localparam int IDX_W  = 6;
    localparam int CNT_W  = 32;
    localparam int DEPTH  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic br_valid = 1'b0;
    logic [ADDR_W-1:0] br_addr = '0;
    logic [HIST_W-1:0] br_hist = '0;
    logic mode_sel = 1'b0;
    logic res_valid, alias_o, cold_o;
    logic [CNT_W-1:0] branch_count, alias_count, cold_count;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [ADDR_W+HIST_W-1:0] m_id [DEPTH];
    bit m_used [DEPTH];
    int e_b = 0, e_a = 0, e_c = 0;

    always #10 clk = ~clk;

    alias_monitor #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_addr(br_addr),
        .br_hist(br_hist), .mode_sel(mode_sel), .res_valid(res_valid),
        .alias_o(alias_o), .cold_o(cold_o), .branch_count(branch_count),
        .alias_count(alias_count), .cold_count(cold_count)
    );

    function automatic int ref_idx(logic [ADDR_W-1:0] a, logic [HIST_W-1:0] h, logic m);
        int lo;
        lo = int'(a) % DEPTH;
        if (m) return ((lo % (1 << (IDX_W - HIST_W))) << HIST_W) | int'(h);
        return lo ^ (int'(h) << (IDX_W - HIST_W));
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic lookup(logic [ADDR_W-1:0] a, logic [HIST_W-1:0] h, logic m, string req);
        int i;
        bit ec, ea;
        @(negedge clk);
        br_valid = 1'b1; br_addr = a; br_hist = h; mode_sel = m;
        i = ref_idx(a, h, m);
        ec = !m_used[i];
        ea = m_used[i] && (m_id[i] != {a, h});
        m_used[i] = 1'b1;
        m_id[i] = {a, h};
        e_b++; if (ea) e_a++; if (ec) e_c++;
        @(negedge clk);
        br_valid = 1'b0;
        check({req, " R2 res_valid"}, res_valid, 1);
        check({req, " alias"}, alias_o, ea);
        check({req, " cold"}, cold_o, ec);
    endtask

    task automatic check_counts(string tag);
        @(negedge clk);
        check({tag, " R9 branch_count"}, branch_count, e_b);
        check({tag, " R9 alias_count"}, alias_count, e_a);
        check({tag, " R9 cold_count"}, cold_count, e_c);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] snap;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < DEPTH; i++) begin m_used[i] = 1'b0; m_id[i] = '0; end
        repeat (3) @(negedge clk);
        check("R1 res_valid in reset", res_valid, 0);
        check("R1 branch_count in reset", branch_count, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 alias_count after reset", alias_count, 0);
        check("R1 cold_count after reset", cold_count, 0);
        check("R1 flags after reset", {alias_o, cold_o}, 0);

        // R3 cold, R4 alias on upper address bit, R6 overwrite, R5 clean
        lookup(16'h0003, 4'h0, 1'b0, "R3 first use");
        lookup(16'h0043, 4'h0, 1'b0, "R4 other pair same slot");
        lookup(16'h0003, 4'h0, 1'b0, "R6 slot now holds other pair");
        lookup(16'h0003, 4'h0, 1'b0, "R5 same pair");
        lookup(16'h0003, 4'h1, 1'b0, "R4 history differs");
        // R7: history lands on top of index field: 0x13 ^ 0x04 = 0x17
        lookup(16'h0013, 4'h1, 1'b0, "R7 xor first");
        lookup(16'h0017, 4'h0, 1'b0, "R7 xor collide");
        // R8: {addr[1:0], hist}: 0x05,A and 0x09,A both give 0x1A
        lookup(16'h0005, 4'hA, 1'b1, "R8 concat first");
        lookup(16'h0009, 4'hA, 1'b1, "R8 concat collide");
        lookup(16'h0009, 4'hB, 1'b1, "R8 concat other slot");
        check_counts("directed");

        // R11: idle cycles leave counts and slots untouched
        snap = branch_count;
        repeat (5) @(negedge clk);
        check("R11 res_valid idle", res_valid, 0);
        check("R11 branch_count idle", branch_count, snap);
        lookup(16'h0009, 4'hB, 1'b1, "R11 slot preserved");

        for (int k = 0; k < 1500; k++) begin
            lookup(ADDR_W'($urandom_range(0, 255)), HIST_W'($urandom_range(0, 15)),
                   1'($urandom_range(0, 1)), "R4 R5 R6 random");
        end
        check_counts("random");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule